// File: doc/BRIEF.md
# Fragmented Buffer Receive Reassembler

The block rebuilds receive frames that arrive split across several buffers. Each buffer is presented on a byte stream as one header word, flagged by a header strobe, followed by the number of payload bytes that the header announces. Two inverted position flags in the header tell whether a buffer opens a frame and whether it closes one. The block tracks the frame position with a three-state machine and appends the payload bytes of consecutive buffers into an internal frame store.

When the closing buffer's last byte is taken, the block gives a one-cycle completion pulse and the total frame length. A consumer reads the stored bytes through a combinational read port. Buffers that break the framing rules are discarded, the frame in progress is abandoned, and a one-cycle error pulse is given. These rule breaks are a continuation with no open frame, a new start inside an open frame, an oversized buffer, and a frame that grows past its limit.

Top module: `frag_reasm`

## Requirements
- R1: While reset is asserted `frame_done`, `frame_err` and `frame_len` are 0 and `s_ready` is low. `s_ready` goes high within four clock cycles after reset is released.
- R2: In a header word, bit 15 = 1 means "not the first buffer of a frame" and bit 14 = 1 means "not the last buffer of a frame". Bits 8:0 give the payload byte count. Bits 13:9 have no effect on the outputs or on the stored data.
- R3: A header with bits 15 and 14 both clear is a whole frame in one buffer. `frame_done` pulses in the cycle after its last payload beat is accepted, or after the header itself if the count is 0. `frame_len` then equals the count, and the bytes are readable at addresses 0 upward.
- R4: A frame made of one opening buffer (15=0, 14=1), any number of middle buffers (15=1, 14=1) and one closing buffer (15=1, 14=0) completes as in R3. `frame_len` equals the sum of the counts, and the bytes are stored contiguously in arrival order.
- R5: A header with bit 15 set while no frame is open is an orphan. `frame_err` pulses in the next cycle, its payload is discarded, no completion follows, and the frame store keeps its earlier contents.
- R6: A header with bit 15 clear while a frame is open raises `frame_err` in the next cycle. The partial frame is dropped, and a new frame starts from this buffer so that the next completion reports only the new frame's bytes.
- R7: A header whose count exceeds 280 raises `frame_err` in the next cycle. Its payload is discarded and any open frame is abandoned.
- R8: A buffer that would take the frame total past 1500 bytes raises `frame_err` in the next cycle, and its payload and the frame are discarded. A total of exactly 1500 completes normally.
- R9: `frame_done` and `frame_err` are single-cycle pulses. `frame_len` changes only together with `frame_done` and holds its value otherwise.
- R10: Once high after reset, `s_ready` stays high, and every beat with `s_valid` high is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Beat valid |
| s_ready | output | 1 | Block can take a beat |
| s_hdr | input | 1 | Beat carries a header word |
| s_word | input | 16 | Header word, or payload byte in bits 7:0 |
| rd_addr | input | 11 | Frame store read address |
| rd_data | output | 8 | Frame store byte at `rd_addr` |
| frame_done | output | 1 | Frame complete pulse |
| frame_len | output | 11 | Byte length of the last completed frame |
| frame_err | output | 1 | Protocol violation pulse |

## Verification
The assertions take for granted that the sender obeys the beat count. A header is offered only after the previous buffer's announced payload bytes have all been sent, and no payload beat is offered when nothing is announced. The bench stimulus is built buffer by buffer: every header is followed by exactly the number of payload beats its count field carries, including the oversized and orphan buffers whose bytes the block throws away. Random choices cover lengths, flag combinations, the ignored header bits and the payload values, but never the beat count itself.

// File: rtl/frag_reasm_pkg.sv
`timescale 1ns/1ps
package frag_reasm_pkg;
  // Header field positions (decoded by the control path)
  localparam int HDR_NOT_FIRST = 15;
  localparam int HDR_NOT_LAST  = 14;
  localparam int CNT_W         = 9;

  typedef enum logic [1:0] {
    POS_BEGIN  = 2'd0,
    POS_MIDDLE = 2'd1,
    POS_END    = 2'd2
  } pos_e;
endpackage

// File: rtl/frag_reasm_rstsync.sv
`timescale 1ns/1ps
module frag_reasm_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/frag_reasm_hdr.sv
`timescale 1ns/1ps
module frag_reasm_hdr
  import frag_reasm_pkg::*;
#(
  parameter int FRAME_MAX = 1500,
  parameter int BUF_MAX   = 280,
  parameter int LW        = $clog2(FRAME_MAX + 1)
) (
  input  logic [15:0]      word,
  input  pos_e             pos,
  input  logic [LW-1:0]    acc,
  output logic             not_last,
  output logic [CNT_W-1:0] cnt,
  output logic [LW-1:0]    base,
  output logic             accept,
  output logic             viol
);
  localparam int SW = LW + 1;

  logic          not_first;
  logic          orphan, restart, too_big, overflow;
  logic [SW-1:0] total;
  logic          unused_hdr_bits;

  assign not_first       = word[HDR_NOT_FIRST];
  assign not_last        = word[HDR_NOT_LAST];
  assign cnt             = word[CNT_W-1:0];
  assign unused_hdr_bits = ^word[HDR_NOT_LAST-1:CNT_W];

  // continuation extends the open frame, a start begins from zero
  assign base     = not_first ? acc : '0;
  assign total    = SW'(base) + SW'(cnt);

  assign orphan   = (pos == POS_BEGIN) && not_first;
  assign restart  = (pos == POS_MIDDLE) && !not_first;
  assign too_big  = cnt > CNT_W'(BUF_MAX);
  assign overflow = total > SW'(FRAME_MAX);

  assign accept   = !orphan && !too_big && !overflow;
  assign viol     = orphan | restart | too_big | overflow;
endmodule

// File: rtl/frag_reasm_ctrl.sv
`timescale 1ns/1ps
module frag_reasm_ctrl
  import frag_reasm_pkg::*;
#(
  parameter int LW = 11,
  parameter int AW = 11
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             s_valid,
  input  logic             s_hdr,
  input  logic [7:0]       s_byte,
  input  logic             d_not_last,
  input  logic [CNT_W-1:0] d_cnt,
  input  logic [LW-1:0]    d_base,
  input  logic             d_accept,
  input  logic             d_viol,
  output logic             s_ready,
  output logic             wr_en,
  output logic [AW-1:0]    wr_addr,
  output logic [7:0]       wr_data,
  output pos_e             pos,
  output logic [LW-1:0]    acc,
  output logic             done,
  output logic             err,
  output logic [LW-1:0]    len
);
  pos_e             pos_q, pos_d;
  logic [CNT_W-1:0] rem_q, rem_d;
  logic             drop_q, drop_d;
  logic [LW-1:0]    acc_q, acc_d;
  logic [LW-1:0]    len_q, len_d;
  logic             done_q, done_d;
  logic             err_q, err_d;
  logic             rdy_q;
  logic             hdr_fire, pay_fire, len_en;

  assign hdr_fire = s_valid && rdy_q && s_hdr;
  assign pay_fire = s_valid && rdy_q && !s_hdr && (rem_q != '0);

  // next-state
  always_comb begin
    pos_d  = pos_q;
    rem_d  = rem_q;
    drop_d = drop_q;
    acc_d  = acc_q;
    len_d  = len_q;
    done_d = 1'b0;
    err_d  = 1'b0;
    wr_en  = 1'b0;
    if (hdr_fire) begin
      err_d = d_viol;
      rem_d = d_cnt;
      if (d_accept) begin
        acc_d  = d_base;
        drop_d = 1'b0;
        pos_d  = d_not_last ? POS_MIDDLE : POS_END;
        if (!d_not_last && (d_cnt == '0)) begin
          done_d = 1'b1;
          len_d  = d_base;
          pos_d  = POS_BEGIN;
        end
      end else begin
        acc_d  = '0;
        drop_d = 1'b1;
        pos_d  = POS_BEGIN;
      end
    end else if (pay_fire) begin
      rem_d = rem_q - 1'b1;
      if (!drop_q) begin
        wr_en = 1'b1;
        acc_d = acc_q + 1'b1;
        if ((rem_q == CNT_W'(1)) && (pos_q == POS_END)) begin
          done_d = 1'b1;
          len_d  = acc_q + 1'b1;
          pos_d  = POS_BEGIN;
        end
      end
    end
  end

  assign len_en = done_d;

  // registers
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      pos_q  <= POS_BEGIN;
      rem_q  <= '0;
      drop_q <= 1'b0;
      acc_q  <= '0;
      len_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      rdy_q  <= 1'b0;
    end else begin
      pos_q  <= pos_d;
      rem_q  <= rem_d;
      drop_q <= drop_d;
      acc_q  <= acc_d;
      done_q <= done_d;
      err_q  <= err_d;
      rdy_q  <= 1'b1;
      if (len_en) len_q <= len_d;
    end
  end

  assign s_ready = rdy_q;
  assign wr_addr = acc_q[AW-1:0];
  assign wr_data = s_byte;
  assign pos     = pos_q;
  assign acc     = acc_q;
  assign done    = done_q;
  assign err     = err_q;
  assign len     = len_q;
endmodule

// File: rtl/frag_reasm_buf.sv
`timescale 1ns/1ps
module frag_reasm_buf #(
  parameter int DEPTH = 1500,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/frag_reasm.sv
`timescale 1ns/1ps
module frag_reasm
  import frag_reasm_pkg::*;
#(
  parameter int FRAME_MAX = 1500,
  parameter int BUF_MAX   = 280,
  localparam int LW       = $clog2(FRAME_MAX + 1),
  localparam int AW       = $clog2(FRAME_MAX)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic          s_hdr,
  input  logic [15:0]   s_word,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic          frame_done,
  output logic [LW-1:0] frame_len,
  output logic          frame_err
);
  logic             arst_n;
  pos_e             pos_w;
  logic [LW-1:0]    acc_w, base_w;
  logic             not_last_w, accept_w, viol_w;
  logic [CNT_W-1:0] cnt_w;
  logic             wr_en_w;
  logic [AW-1:0]    wr_addr_w;
  logic [7:0]       wr_data_w;

  frag_reasm_rstsync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(arst_n)
  );

  frag_reasm_hdr #(.FRAME_MAX(FRAME_MAX), .BUF_MAX(BUF_MAX), .LW(LW)) u_hdr (
    .word(s_word), .pos(pos_w), .acc(acc_w),
    .not_last(not_last_w), .cnt(cnt_w), .base(base_w),
    .accept(accept_w), .viol(viol_w)
  );

  frag_reasm_ctrl #(.LW(LW), .AW(AW)) u_ctrl (
    .clk(clk), .arst_n(arst_n),
    .s_valid(s_valid), .s_hdr(s_hdr), .s_byte(s_word[7:0]),
    .d_not_last(not_last_w), .d_cnt(cnt_w), .d_base(base_w),
    .d_accept(accept_w), .d_viol(viol_w),
    .s_ready(s_ready), .wr_en(wr_en_w), .wr_addr(wr_addr_w), .wr_data(wr_data_w),
    .pos(pos_w), .acc(acc_w),
    .done(frame_done), .err(frame_err), .len(frame_len)
  );

  frag_reasm_buf #(.DEPTH(FRAME_MAX), .AW(AW)) u_buf (
    .clk(clk), .wr_en(wr_en_w), .wr_addr(wr_addr_w), .wr_data(wr_data_w),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );
endmodule

// File: rtl/frag_reasm_chk.sv
`timescale 1ns/1ps
module frag_reasm_chk
  import frag_reasm_pkg::*;
#(
  parameter int FRAME_MAX = 1500,
  parameter int BUF_MAX   = 280,
  parameter int LW        = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          s_valid,
  input logic          s_ready,
  input logic          s_hdr,
  input logic [15:0]   s_word,
  input logic          frame_done,
  input logic          frame_err,
  input logic [LW-1:0] frame_len,
  input logic [1:0]    pos
);
  logic hdr_take;
  assign hdr_take = s_valid && s_ready && s_hdr;

  assert_orphan_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_take && pos == 2'd0 && s_word[15]) |=> frame_err);

  assert_restart_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_take && pos == 2'd1 && !s_word[15]) |=> frame_err);

  assert_buf_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_take && (s_word[8:0] > 9'(BUF_MAX))) |=> frame_err);

  assert_len_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (frame_len <= LW'(FRAME_MAX)));

  assert_len_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |-> $stable(frame_len));

  assert_done_to_begin_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (pos == 2'd0));

  assert_pos_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pos != 2'd3);

  assert_ready_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |=> s_ready);
endmodule

bind frag_reasm frag_reasm_chk #(.FRAME_MAX(FRAME_MAX), .BUF_MAX(BUF_MAX), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_hdr(s_hdr),
  .s_word(s_word), .frame_done(frame_done), .frame_err(frame_err),
  .frame_len(frame_len), .pos(pos_w)
);

// File: tb/frag_reasm_bench.sv
`timescale 1ns/1ps
module frag_reasm_bench;
  localparam int FMAX = 1500;
  localparam int BMAX = 280;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        s_valid, s_ready, s_hdr;
  logic [15:0] s_word;
  logic [10:0] rd_addr;
  logic [7:0]  rd_data;
  logic        frame_done, frame_err;
  logic [10:0] frame_len;

  int vectors = 0;
  int miss    = 0;

  // reference state
  int         m_pos  = 0;   // 0 begin, 1 middle, 2 end
  int         m_acc  = 0;
  int         m_rem  = 0;
  bit         m_drop = 0;
  int         m_len  = 0;
  logic [7:0] exp_mem [FMAX];

  always #5 clk = ~clk;

  frag_reasm u_frag_reasm (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_hdr(s_hdr),
    .s_word(s_word), .rd_addr(rd_addr), .rd_data(rd_data),
    .frame_done(frame_done), .frame_len(frame_len), .frame_err(frame_err)
  );

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
    $finish;
  endtask

  initial begin
    #1_500_000;
    vectors++;
    miss++;
    $display("FAIL watchdog: run did not finish, got hung, expected completion");
    summary();
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miss++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // expected behaviour of one accepted beat, from the requirements
  task automatic model(input bit h, input logic [15:0] w, output bit ed, output bit ee);
    ed = 0; ee = 0;
    if (h) begin
      bit nf, nl, ok;
      int cnt, base;
      nf = w[15]; nl = w[14]; cnt = int'(w[8:0]);
      base = nf ? m_acc : 0;
      ok = 1;
      if (m_pos == 0 && nf) begin ee = 1; ok = 0; end
      if (m_pos == 1 && !nf) ee = 1;
      if (cnt > BMAX || base + cnt > FMAX) begin ee = 1; ok = 0; end
      m_rem = cnt;
      if (ok) begin
        m_acc = base; m_drop = 0;
        m_pos = nl ? 1 : 2;
        if (!nl && cnt == 0) begin ed = 1; m_len = base; m_pos = 0; end
      end else begin
        m_acc = 0; m_drop = 1; m_pos = 0;
      end
    end else begin
      m_rem--;
      if (!m_drop) begin
        exp_mem[m_acc] = w[7:0];
        m_acc++;
        if (m_rem == 0 && m_pos == 2) begin ed = 1; m_len = m_acc; m_pos = 0; end
      end
    end
  endtask

  task automatic check_mem(input string tag);
    int bad = 0;
    for (int i = 0; i < m_len; i++) begin
      rd_addr = 11'(i);
      #1;
      if (rd_data !== exp_mem[i]) bad++;
    end
    check(bad == 0, {tag, " stored bytes"}, bad, 0);
    @(negedge clk);
  endtask

  task automatic beat(input bit h, input logic [15:0] w, input string tag);
    bit ed, ee;
    s_valid = 1'b1; s_hdr = h; s_word = w;
    @(posedge clk);
    @(negedge clk);
    s_valid = 1'b0; s_hdr = 1'b0;
    model(h, w, ed, ee);
    vectors++;
    if (frame_done !== ed || frame_err !== ee || frame_len !== 11'(m_len) || s_ready !== 1'b1) begin
      miss++;
      $display("FAIL %s: actual done=%0b err=%0b len=%0d rdy=%0b expected done=%0b err=%0b len=%0d rdy=1",
               tag, frame_done, frame_err, frame_len, s_ready, ed, ee, m_len);
    end
    if (ed) check_mem(tag);
  endtask

  task automatic send_buf(input bit nf, input bit nl, input int cnt, input logic [4:0] fill,
                          input string tag);
    beat(1'b1, {nf, nl, fill, 9'(cnt)}, tag);
    for (int i = 0; i < cnt; i++) beat(1'b0, 16'($urandom), tag);
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd24680);
    rst_n = 1'b0; s_valid = 1'b0; s_hdr = 1'b0; s_word = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    check(frame_done === 1'b0 && frame_err === 1'b0, "R1 pulses in reset", int'(frame_done | frame_err), 0);
    check(frame_len === 11'd0, "R1 length in reset", int'(frame_len), 0);
    check(s_ready === 1'b0, "R1 ready in reset", int'(s_ready), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(s_ready === 1'b1, "R1 ready after reset", int'(s_ready), 1);

    send_buf(0, 0, 0, 5'd0, "R3");                 // empty single-buffer frame
    send_buf(0, 0, 5, 5'h1f, "R2");                // ignored bits all ones
    send_buf(0, 0, 280, 5'h0a, "R3");              // largest single buffer
    send_buf(0, 1, 10, 5'd3, "R4");
    send_buf(1, 1, 0, 5'd0, "R4");
    send_buf(1, 0, 7, 5'd6, "R4");                 // frame of 17 bytes
    send_buf(1, 0, 6, 5'd1, "R5");                 // orphan
    check_mem("R5");                               // store still holds the 17-byte frame
    check(frame_len === 11'd17, "R9 length held after error", int'(frame_len), 17);
    send_buf(0, 1, 4, 5'd0, "R6");
    send_buf(0, 0, 3, 5'd0, "R6");                 // restart, only 3 bytes reported
    check(frame_len === 11'd3, "R6 restarted length", int'(frame_len), 3);
    send_buf(0, 0, 281, 5'd0, "R7");
    send_buf(0, 1, 5, 5'd0, "R7");
    send_buf(1, 0, 300, 5'd0, "R7");
    check(frame_len === 11'd3, "R7 no completion", int'(frame_len), 3);
    send_buf(0, 1, 280, 5'd0, "R8");
    for (int k = 0; k < 3; k++) send_buf(1, 1, 280, 5'd0, "R8");
    send_buf(1, 1, 280, 5'd0, "R8");
    send_buf(1, 0, 100, 5'd0, "R8");               // exactly 1500
    check(frame_len === 11'd1500, "R8 full-size frame", int'(frame_len), 1500);
    send_buf(0, 1, 280, 5'd0, "R8");
    for (int k = 0; k < 4; k++) send_buf(1, 1, 280, 5'd0, "R8");
    send_buf(1, 0, 101, 5'd0, "R8");               // 1501 rejected
    check(frame_len === 11'd1500, "R8 over-size dropped", int'(frame_len), 1500);

    for (int n = 0; n < 240; n++) begin
      int r;
      r = int'($urandom % 10);
      if (r == 0) begin
        send_buf(1, 1'($urandom), int'($urandom % 20), 5'($urandom), "R5");
      end else if (r == 1) begin
        send_buf(0, 1, int'($urandom % 20), 5'($urandom), "R6");
        send_buf(0, 0, int'($urandom % 20), 5'($urandom), "R6");
      end else if (r == 2) begin
        send_buf(0, 0, 281 + int'($urandom % 231), 5'($urandom), "R7");
      end else begin
        int k;
        k = 1 + int'($urandom % 4);
        for (int b = 0; b < k; b++)
          send_buf(b != 0, b != k - 1, int'($urandom % 41), 5'($urandom), (k == 1) ? "R3" : "R4");
      end
    end

    check(s_ready === 1'b1, "R10 ready at end", int'(s_ready), 1);
    summary();
  end
endmodule